// File: doc/BRIEF.md
# External Bus Wait-State Generator

This block lengthens external bus cycles so that a fast bus master can work with slow off-chip memory and peripherals. Three external address spaces (program, data and I/O) each get their own 3-bit wait count. The counts live in a 16-bit control register. Software writes and reads that register with I/O-space accesses to one fixed address. The same register also keeps a 2-bit bus-visibility mode, which other logic uses.

When the master starts an external access, it pulses a start strobe and names the space. The block picks that space's wait count and holds a stall output high for at least that many clock cycles. Once the programmed count has run out, the access completes on the first cycle in which the external ready input is high. The ready input can only add cycles after the programmed minimum. It can never cut that minimum short. An access with a count of zero and ready high completes in its start cycle with no stall.

Top module: `ext_wait_gen`

## Requirements
- R1: After reset, a read of the control register returns 0x07FF. All three wait counts are 7 and the visibility mode output is 2'b11.
- R2: The program-space count sits in register bits 2:0, the data-space count in bits 5:3 and the I/O-space count in bits 8:6. Space code 2'b00 selects program, 2'b01 selects data and 2'b10 selects I/O.
- R3: With ready held high, an access to a space whose count is N (1 to 7) keeps the stall output high for exactly N cycles, counting from the start cycle. The done output pulses in cycle N.
- R4: With a count of 0 and ready high, done is high and stall is low in the start cycle itself.
- R5: Done is asserted only in a cycle where ready is high and at least N cycles have elapsed since the start cycle. Ready being low before that point adds no cycles.
- R6: Register bits 15:11 always read as zero, and writing ones to them has no effect.
- R7: The register is written only when the I/O write strobe is high and the address is 0xFFFF. Read data is zero unless the read strobe is high and the address is 0xFFFF.
- R8: A register write during an access does not change that access's length. The new value applies from the next access.
- R9: Space code 2'b11 inserts no programmed wait states. Only ready controls when that access ends.
- R10: The visibility mode output always equals register bits 10:9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | I/O-space write strobe |
| cfg_rd | input | 1 | I/O-space read strobe |
| cfg_addr | input | 16 | I/O address |
| cfg_wdata | input | 16 | I/O write data |
| cfg_rdata | output | 16 | Register read data (zero when not selected) |
| acc_start | input | 1 | Pulses in the first cycle of an external access |
| acc_space | input | 2 | Space of the access: 00 program, 01 data, 10 I/O, 11 none |
| ext_ready | input | 1 | External ready; low asks for more cycles |
| acc_stall | output | 1 | High while the access may not yet complete |
| acc_done | output | 1 | High in the cycle the access completes |
| bus_vis | output | 2 | Stored bus-visibility mode |

## Verification
The bench targets three kinds of corner case.

- **Ready low inside the programmed window.** A design that adds these low-ready cycles to the count would stretch the access past N cycles.
- **Ready low after the window.** A design that ignores ready there would finish early.
- **Zero count with ready high.** A design that registers the completion would add a cycle.

The bench also writes the register in the middle of an access. A design that reloads the live counter from the new field would change that access's length. Writes that land on reserved bits or on a neighbouring address are covered too. A design that stores those bits, or decodes the address too loosely, would return a different read-back value or a different wait length.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
   localparam int SPACE_W = 2;
   typedef enum logic [SPACE_W-1:0] {
      SP_PROG = 2'b00,
      SP_DATA = 2'b01,
      SP_IO   = 2'b10,
      SP_NONE = 2'b11
   } space_e;
endpackage

// File: rtl/wsg_ctrl_reg.sv
module wsg_ctrl_reg #(
   parameter int          DATA_W   = 16,
   parameter int          ADDR_W   = 16,
   parameter logic [15:0] REG_ADDR = 16'hFFFF,
   parameter int          FIELD_W  = 3,
   parameter int          N_SPACE  = 3,
   parameter int          VIS_W    = 2,
   parameter bit          RDATA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] image
);
   localparam int WAIT_BITS = FIELD_W * N_SPACE;
   localparam int USED_BITS = WAIT_BITS + VIS_W;
   localparam logic [DATA_W-1:0] WMASK = DATA_W'((64'd1 << USED_BITS) - 64'd1);
   localparam logic [DATA_W-1:0] RST_VAL = WMASK;

   initial begin
      if (USED_BITS > DATA_W) $error("wsg_ctrl_reg: fields do not fit in register");
      if (ADDR_W > 16) $error("wsg_ctrl_reg: address wider than decode constant");
   end

   logic hit;
   logic [DATA_W-1:0] reg_q;

   assign hit = (addr == REG_ADDR[ADDR_W-1:0]);

   always_ff @(posedge clk) begin
      if (!rst_n)         reg_q <= RST_VAL;
      else if (wr && hit) reg_q <= wdata & WMASK;
   end

   assign image = reg_q;

   generate
      if (RDATA_REG) begin : g_rd_flop
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= (rd && hit) ? reg_q : '0;
         end
         assign rdata = rd_q;
      end else begin : g_rd_comb
         assign rdata = (rd && hit) ? reg_q : '0;
      end
   endgenerate
endmodule

// File: rtl/wsg_field_sel.sv
module wsg_field_sel #(
   parameter int DATA_W  = 16,
   parameter int FIELD_W = 3,
   parameter int N_SPACE = 3,
   parameter int SPACE_W = 2
) (
   input  logic [DATA_W-1:0]  image,
   input  logic [SPACE_W-1:0] space,
   output logic [FIELD_W-1:0] waits
);
   initial begin
      if (N_SPACE > (1 << SPACE_W)) $error("wsg_field_sel: too many spaces for select width");
   end

   logic [FIELD_W-1:0] field [N_SPACE];

   for (genvar g = 0; g < N_SPACE; g++) begin : g_field
      assign field[g] = image[g*FIELD_W +: FIELD_W];
   end

   always_comb begin
      waits = '0;
      for (int s = 0; s < N_SPACE; s++) begin
         if (space == SPACE_W'(s)) waits = field[s];
      end
   end
endmodule

// File: rtl/wsg_cycle_fsm.sv
module wsg_cycle_fsm #(
   parameter int FIELD_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FIELD_W-1:0] load,
   input  logic               ready,
   output logic               stall,
   output logic               done,
   output logic               busy
);
   logic               busy_q;
   logic [FIELD_W-1:0] cnt_q;
   logic [FIELD_W-1:0] cur;
   logic               active;

   assign active = busy_q | start;
   assign cur    = busy_q ? cnt_q : load;
   assign done   = active && (cur == '0) && ready;
   assign stall  = active && !done;
   assign busy   = busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (done) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (active) begin
         busy_q <= 1'b1;
         cnt_q  <= (cur == '0) ? '0 : cur - 1'b1;
      end
   end
endmodule

// File: rtl/ext_wait_gen.sv
module ext_wait_gen #(
   parameter int          DATA_W    = 16,
   parameter int          ADDR_W    = 16,
   parameter logic [15:0] REG_ADDR  = 16'hFFFF,
   parameter int          FIELD_W   = 3,
   parameter int          N_SPACE   = 3,
   parameter int          VIS_W     = 2,
   parameter bit          RDATA_REG = 1'b0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_wr,
   input  logic                        cfg_rd,
   input  logic [ADDR_W-1:0]           cfg_addr,
   input  logic [DATA_W-1:0]           cfg_wdata,
   output logic [DATA_W-1:0]           cfg_rdata,
   input  logic                        acc_start,
   input  logic [wsg_pkg::SPACE_W-1:0] acc_space,
   input  logic                        ext_ready,
   output logic                        acc_stall,
   output logic                        acc_done,
   output logic [VIS_W-1:0]            bus_vis
);
   localparam int VIS_LSB = FIELD_W * N_SPACE;

   logic [DATA_W-1:0]  image;
   logic [FIELD_W-1:0] wait_sel;
   logic               fsm_busy;

   wsg_ctrl_reg #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR),
      .FIELD_W(FIELD_W), .N_SPACE(N_SPACE), .VIS_W(VIS_W), .RDATA_REG(RDATA_REG)
   ) u_reg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .rd(cfg_rd), .addr(cfg_addr),
      .wdata(cfg_wdata), .rdata(cfg_rdata), .image(image)
   );

   wsg_field_sel #(
      .DATA_W(DATA_W), .FIELD_W(FIELD_W), .N_SPACE(N_SPACE), .SPACE_W(wsg_pkg::SPACE_W)
   ) u_sel (
      .image(image), .space(acc_space), .waits(wait_sel)
   );

   wsg_cycle_fsm #(.FIELD_W(FIELD_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .start(acc_start), .load(wait_sel),
      .ready(ext_ready), .stall(acc_stall), .done(acc_done), .busy(fsm_busy)
   );

   assign bus_vis = image[VIS_LSB +: VIS_W];
endmodule

// File: rtl/wsg_checker.sv
module wsg_checker #(
   parameter int DATA_W  = 16,
   parameter int FIELD_W = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               acc_start,
   input logic               ext_ready,
   input logic               acc_stall,
   input logic               acc_done,
   input logic               fsm_busy,
   input logic [FIELD_W-1:0] wait_sel,
   input logic [DATA_W-1:0]  cfg_rdata
);
   // R4: zero count with ready high completes in the start cycle
   a_r4_zero_wait_fast: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_start && !fsm_busy && wait_sel == '0 && ext_ready) |-> (acc_done && !acc_stall));

   // R3: a nonzero count never completes in the start cycle
   a_r3_min_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_start && !fsm_busy && wait_sel != '0) |-> !acc_done);

   // R5: completion needs ready high
   a_r5_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
      acc_done |-> ext_ready);

   // R3: stall and done are exclusive
   a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_done && acc_stall));

   // R5: a stalled access is still in flight on the next cycle
   a_r5_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
      acc_stall |=> fsm_busy);

   // R6: reserved bits read as zero
   a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[DATA_W-1:11] == '0);
endmodule

bind ext_wait_gen wsg_checker #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .ext_ready(ext_ready),
   .acc_stall(acc_stall), .acc_done(acc_done), .fsm_busy(fsm_busy),
   .wait_sel(wait_sel), .cfg_rdata(cfg_rdata)
);

// File: tb/ext_wait_gen_bench.sv
module ext_wait_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
   logic [15:0] cfg_addr = '0, cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic        acc_start = 1'b0;
   logic [1:0]  acc_space = 2'b00;
   logic        ext_ready = 1'b1;
   logic        acc_stall, acc_done;
   logic [1:0]  bus_vis;

   int checks = 0, fails = 0, cyc = 0;

   always #2.5 clk = ~clk;

   ext_wait_gen u_ext_wait_gen (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_start(acc_start),
      .acc_space(acc_space), .ext_ready(ext_ready), .acc_stall(acc_stall),
      .acc_done(acc_done), .bus_vis(bus_vis)
   );

   // behavioural reference: elapsed cycles against a latched target
   int m_w[3];
   int m_vis;
   bit m_busy;
   int m_target, m_elapsed;

   function automatic int m_waits(input logic [1:0] sp);
      return (sp == 2'b11) ? 0 : m_w[sp];
   endfunction
   function automatic logic [15:0] m_image();
      return 16'((m_vis << 9) | (m_w[2] << 6) | (m_w[1] << 3) | m_w[0]);
   endfunction

   always @(posedge clk) begin
      int tgt, el;
      bit act, dn;
      if (!rst_n) begin
         m_w[0] = 7; m_w[1] = 7; m_w[2] = 7; m_vis = 3;
         m_busy = 0; m_target = 0; m_elapsed = 0;
      end else begin
         act = m_busy || acc_start;
         tgt = m_busy ? m_target : m_waits(acc_space);
         el  = m_busy ? m_elapsed : 0;
         dn  = act && (el >= tgt) && ext_ready;
         if (act) begin
            if (dn) m_busy = 0;
            else begin
               m_target = tgt; m_elapsed = el + 1; m_busy = 1;
            end
         end
         if (cfg_wr && cfg_addr == 16'hFFFF) begin
            m_w[0] = int'(cfg_wdata[2:0]); m_w[1] = int'(cfg_wdata[5:3]);
            m_w[2] = int'(cfg_wdata[8:6]); m_vis = int'(cfg_wdata[10:9]);
         end
      end
   end

   // per-cycle comparison (R3 R5 R7 R10)
   always @(negedge clk) begin
      int tgt, el;
      bit act, dn;
      logic [15:0] erd;
      if (rst_n) begin
         act = m_busy || acc_start;
         tgt = m_busy ? m_target : m_waits(acc_space);
         el  = m_busy ? m_elapsed : 0;
         dn  = act && (el >= tgt) && ext_ready;
         erd = (cfg_rd && cfg_addr == 16'hFFFF) ? m_image() : 16'h0;
         checks++;
         if (acc_done !== dn || acc_stall !== (act && !dn) || cfg_rdata !== erd
             || bus_vis !== 2'(m_vis)) begin
            fails++;
            $display("FAIL R3/R5/R7/R10 model t=%0t: done=%b stall=%b rdata=%h vis=%b exp %b %b %h %b",
                     $time, acc_done, acc_stall, cfg_rdata, bus_vis, dn, act && !dn, erd, 2'(m_vis));
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   task automatic cfg_write(input logic [15:0] a, input logic [15:0] d);
      @(posedge clk); #1; cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
      @(posedge clk); #1; cfg_wr = 0;
   endtask

   task automatic cfg_read(input logic [15:0] a, output logic [15:0] d);
      @(posedge clk); #1; cfg_rd = 1; cfg_addr = a;
      @(negedge clk); d = cfg_rdata;
      @(posedge clk); #1; cfg_rd = 0;
   endtask

   function automatic int exp_cycles(input int n, input int lo_from, input int lo_len);
      for (int k = 0; k < 100; k++)
         if (k >= n && !(k >= lo_from && k < lo_from + lo_len)) return k;
      return -1;
   endfunction

   task automatic run_access(input logic [1:0] sp, input int lo_from, input int lo_len,
                             output int cycles);
      cycles = -1;
      for (int k = 0; k < 60; k++) begin
         @(posedge clk); #1;
         acc_start = (k == 0); acc_space = sp;
         ext_ready = !(k >= lo_from && k < lo_from + lo_len);
         @(negedge clk);
         if (acc_done) begin cycles = k; break; end
      end
      @(posedge clk); #1; acc_start = 0; ext_ready = 1;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] rd;
      int c;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R1 reset image and visibility
      cfg_read(16'hFFFF, rd);
      check(rd == 16'h07FF, "R1 reset read", rd, 16'h07FF);
      check(bus_vis == 2'b11, "R1 reset vis", bus_vis, 3);
      // R2 R3 reset counts of 7 for each space
      for (int s = 0; s < 3; s++) begin
         run_access(2'(s), 0, 0, c);
         check(c == 7, "R2/R3 reset wait", c, 7);
      end

      // R6 R10 write with reserved bits set: prog 2, data 5, io 0, vis 01
      cfg_write(16'hFFFF, 16'hFA2A);
      cfg_read(16'hFFFF, rd);
      check(rd == 16'h022A, "R6 reserved masked", rd, 16'h022A);
      check(bus_vis == 2'b01, "R10 vis follows", bus_vis, 1);

      // R7 other address ignored, read elsewhere zero
      cfg_write(16'hFFFE, 16'h01FF);
      cfg_read(16'h7FFF, rd);
      check(rd == 16'h0000, "R7 unselected read", rd, 0);
      cfg_read(16'hFFFF, rd);
      check(rd == 16'h022A, "R7 stray write ignored", rd, 16'h022A);

      // R2 R3 programmed counts
      run_access(2'b00, 0, 0, c); check(c == 2, "R2/R3 program wait", c, 2);
      run_access(2'b01, 0, 0, c); check(c == 5, "R2/R3 data wait", c, 5);
      // R4 zero count completes at once
      run_access(2'b10, 0, 0, c); check(c == 0, "R4 io zero wait", c, 0);

      // R5 ready low inside and after the window
      run_access(2'b01, 1, 2, c); check(c == exp_cycles(5, 1, 2), "R5 low inside window", c, 5);
      run_access(2'b01, 5, 3, c); check(c == exp_cycles(5, 5, 3), "R5 low after window", c, 8);
      run_access(2'b00, 0, 4, c); check(c == exp_cycles(2, 0, 4), "R5 low spanning window", c, 4);
      run_access(2'b10, 0, 2, c); check(c == exp_cycles(0, 0, 2), "R5 zero count ready low", c, 2);

      // R9 no-space code
      run_access(2'b11, 0, 0, c); check(c == 0, "R9 none fast", c, 0);
      run_access(2'b11, 0, 3, c); check(c == 3, "R9 none ready only", c, 3);

      // R8 write mid-access: data field to 0, current access keeps 5
      fork
         run_access(2'b01, 0, 0, c);
         begin
            repeat (2) @(posedge clk);
            #1 cfg_wr = 1; cfg_addr = 16'hFFFF; cfg_wdata = 16'h0202;
            @(posedge clk); #1 cfg_wr = 0;
         end
      join
      check(c == 5, "R8 in-flight unchanged", c, 5);
      run_access(2'b01, 0, 0, c); check(c == 0, "R8 next access uses new", c, 0);

      repeat (3) @(posedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule